// File: doc/BRIEF.md
# Gray-coded counter clock crossing

This block keeps a free-running count in one clock domain and presents a continuously refreshed copy of it in a second, asynchronous domain, with no handshake between the two. The source side advances a binary counter by exactly one on every enabled source clock edge. A register in that same domain holds the Gray encoding of the counter. That registered Gray word is the only signal that crosses into the destination domain.

In the destination domain every Gray bit passes through a chain of synchronizer flops, two by default. The synchronized word is then decoded back to binary with a running XOR taken from the most significant bit downward. The decoded value goes through one more register before it reaches the output. Only one Gray bit changes between neighbouring counts. A sample caught during an update therefore resolves to either the old count or the new one, so the output may lag the source by a few cycles but never shows a value the source counter did not hold. The block relies on a stride of one; larger steps break the single-bit property and are not supported.

Top module: `gray_count_xfer`

## Requirements
- R1: After src_rst_n is released, src_count starts at 0. It rises by exactly one on each src_clk rising edge where src_en is 1, and holds its value on edges where src_en is 0.
- R2: src_count wraps from 2^CNT_W-1 to 0. With the default CNT_W of 8 this is from 255 to 0.
- R3: The crossing word is a src_clk register holding bin ^ (bin >> 1) of the counter value. Any two consecutive values of that register differ in at most one bit, including across the wrap.
- R4: Each crossing bit passes through SYNC_STAGES destination flops (default 2) before it is decoded. The decoder reproduces binary as b[i] = XOR of g[CNT_W-1:i].
- R5: dst_count is a dst_clk register that reads 0 while dst_rst_n is low and on the first dst_clk edge after dst_rst_n is released.
- R6: Every new value on dst_count is a value src_count held, reached in increasing order modulo 2^CNT_W. When src_clk runs slower than dst_clk, each change of dst_count is a step of exactly one.
- R7: Once src_en has been low for one src_clk cycle, dst_count equals src_count within SYNC_STAGES+2 dst_clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_en | input | 1 | Count enable, sampled on src_clk |
| src_count | output | CNT_W | Binary source counter value |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_count | output | CNT_W | Synchronized, decoded count in the destination domain |

## Verification
The assertions assume that src_en is stable around src_clk edges and that the two resets are released while the counter is idle. The single-bit Gray property and the unit-stride property are checked only inside the source domain, where they hold whatever the clock ratio. The stimulus changes src_en only on falling edges of src_clk. It runs the source clock first slower and then faster than the destination clock, with idle gaps and enough counts to cross the wrap several times, so the destination sees both single steps and multi-count jumps.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    localparam int unsigned GCC_CNT_W_DEF = 8;
    localparam int unsigned GCC_SYNC_DEF  = 2;
endpackage

// File: rtl/gcc_src_counter.sv
module gcc_src_counter #(
    parameter int unsigned CNT_W = gcc_pkg::GCC_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] gray_q
);
    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (en) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // registered encode: the crossing word never sees a settling binary value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gray_q <= '0;
        else        gray_q <= count_q ^ (count_q >> 1);
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (count_q == $past(count_q) + 1'b1));

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count_q));

    // R3
    gray_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/gcc_sync.sv
module gcc_sync #(
    parameter int unsigned WIDTH  = gcc_pkg::GCC_CNT_W_DEF,
    parameter int unsigned STAGES = gcc_pkg::GCC_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gcc_decoder.sv
module gcc_decoder #(
    parameter int unsigned CNT_W = gcc_pkg::GCC_CNT_W_DEF
) (
    input  logic [CNT_W-1:0] gray,
    output logic [CNT_W-1:0] bin
);
    assign bin[CNT_W-1] = gray[CNT_W-1];
    for (genvar i = CNT_W - 2; i >= 0; i--) begin : g_prefix
        assign bin[i] = bin[i+1] ^ gray[i];
    end

    // R4
    always_comb begin
        decode_roundtrip_chk: assert ((bin ^ (bin >> 1)) == gray);
    end
endmodule

// File: rtl/gray_count_xfer.sv
module gray_count_xfer #(
    parameter int unsigned CNT_W       = gcc_pkg::GCC_CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = gcc_pkg::GCC_SYNC_DEF
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_en,
    output logic [CNT_W-1:0] src_count,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [CNT_W-1:0] dst_count
);
    logic [CNT_W-1:0] xfer_gray;
    logic [CNT_W-1:0] dst_gray;
    logic [CNT_W-1:0] dst_bin;

    gcc_src_counter #(.CNT_W(CNT_W)) u_src (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .en      (src_en),
        .count_q (src_count),
        .gray_q  (xfer_gray)
    );

    gcc_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (xfer_gray),
        .q     (dst_gray)
    );

    gcc_decoder #(.CNT_W(CNT_W)) u_dec (
        .gray (dst_gray),
        .bin  (dst_bin)
    );

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_count <= '0;
        else            dst_count <= dst_bin;
    end

    // R5
    dst_reset_zero_chk: assert property (@(posedge dst_clk)
        !dst_rst_n |=> (dst_count == '0));
endmodule

// File: tb/tb_gray_count_xfer.sv
`timescale 1ns/1ps
module tb_gray_count_xfer;
    localparam int unsigned W = 8;
    localparam int unsigned MOD = 1 << W;

    logic src_clk = 1'b0, dst_clk = 1'b0;
    logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic src_en = 1'b0;
    logic [W-1:0] src_count, dst_count;

    real src_half = 3.65;
    int  n_checks = 0, n_fail = 0;
    int  model = 0;
    bit  slow_src = 1'b1;
    bit  mon_on = 1'b0;
    int  expq[$];

    always #(src_half) src_clk = ~src_clk;
    always #2.5 dst_clk = ~dst_clk;

    gray_count_xfer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_en(src_en),
        .src_count(src_count), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_count(dst_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // driver: pushes every count the source takes into the scoreboard
    task automatic run_counts(input int n);
        @(negedge src_clk) src_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge src_clk);
            model = (model + 1) % MOD;
            expq.push_back(model);
            if (k % 37 == 0) chk("R1 step", src_count, model);
            if (model == 0) chk("R2 wrap", src_count, 0);
        end
        src_en = 1'b0;
    endtask

    task automatic idle_and_settle();
        @(negedge src_clk);
        repeat (3) @(negedge src_clk);
        chk("R1 hold", src_count, model);
        repeat (4) @(negedge dst_clk); // SYNC_STAGES+2 dst cycles
        chk("R7 settle", dst_count, model);
    endtask

    // monitor: each change of dst_count pops the scoreboard up to that value
    int last_dst = 0;
    always @(negedge dst_clk) begin
        if (mon_on && dst_count != last_dst) begin
            int skipped = 0;
            while (expq.size() > 0 && expq[0] != dst_count) begin
                void'(expq.pop_front());
                skipped++;
            end
            if (expq.size() == 0) begin
                chk("R6 value held by source", dst_count, last_dst);
            end else begin
                void'(expq.pop_front());
                chk("R6 ordered", 1, 1);
                if (slow_src) chk("R6 unit step", skipped, 0);
            end
            last_dst = dst_count;
        end
    end

    initial begin
        repeat (150000) @(posedge dst_clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge dst_clk);
        chk("R5 dst reset", dst_count, 0);
        chk("R1 src reset", src_count, 0);
        @(negedge src_clk) begin src_rst_n = 1'b1; dst_rst_n = 1'b1; end
        repeat (3) @(negedge dst_clk);
        chk("R5 after release", dst_count, 0);
        chk("R1 idle after reset", src_count, 0);
        mon_on = 1'b1;

        // source slower than destination: every count seen one by one
        run_counts(300);
        idle_and_settle();
        run_counts(5);
        idle_and_settle();

        // source faster than destination: jumps allowed, order preserved
        slow_src = 1'b0;
        src_half = 1.1;
        repeat (4) @(negedge src_clk);
        run_counts(700);
        idle_and_settle();
        run_counts(1);
        idle_and_settle();

        chk("R6 scoreboard drained", expq.size(), 0);
        finish_run();
    end
endmodule